// File: doc/BRIEF.md
# Asymmetric Decode-Slot Steering with Micro-op Buffer

This block sits between a buffer of length-decoded instructions and the rename stage. Each cycle it looks at the oldest `NSLOT` instructions of that buffer. For each one it receives a valid flag, a micro-op count and a small tag. It hands them, oldest first, to a row of decode slots. Slot 0 is the wide slot and may emit up to four micro-ops for one instruction. Every other slot is narrow and emits exactly one. The micro-ops produced in a cycle are written in program order into an internal micro-op buffer. The next stage drains that buffer one entry per cycle, so the buffer smooths out the uneven decode rate.

Steering stops at the first instruction that cannot be placed. That is an invalid window entry, or a multi-micro-op instruction that has reached a narrow slot. Such an instruction and everything behind it stay in the window. On a later cycle the window has advanced, that instruction arrives in slot 0, and it decodes there. An instruction that needs more than four micro-ops is marked for a sequencer. It then emits a single marked entry micro-op and occupies the cycle alone.

A cycle is all-or-nothing. If the buffer does not have room for every micro-op the cycle would produce, nothing is consumed and nothing is written. A flush input discards the current window decision and empties the buffer. The upstream buffer uses the consumed count to advance its window.

Top module: `dsteer_top`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, the micro-op buffer is empty (`uq_valid` low). This holds even if reset is applied with entries present.
- R2: When window entry 0 is valid with a count c from 1 to 4, slot 0 fires (`slot_fire` bit 0). The buffer then receives c micro-ops with that instruction's tag, index 0 to c-1 in order, and the sequencer mark clear.
- R3: A narrow slot s (s at least 1) fires only if slot s-1 fired, entry s is valid, and entry s needs exactly one micro-op. `slot_fire` is therefore always a run of ones starting at bit 0, and `consume_cnt` equals the number of set bits.
- R4: When entry 0 has a count above 4 (5 to 7), `seq_req` is high and `slot_fire` is 3'b001. The buffer receives a single micro-op with index 0 and the sequencer mark set.
- R5: If the free space in the buffer (depth minus occupancy, counted before this cycle's pop) is smaller than the cycle's micro-op total, then `slot_fire`, `consume_cnt` and `seq_req` are zero and nothing is written. A total equal to the free space is accepted.
- R6: The buffer delivers micro-ops in the order they were written, one per cycle with `uq_pop` high. `uq_pop` on an empty buffer changes nothing.
- R7: While `flush` is high, nothing fires and nothing is written. The cycle after a flush the buffer is empty.
- R8: An invalid window entry ends the cycle's group. A valid entry behind it is not steered, and an invalid entry 0 means `consume_cnt` is 0.
- R9: The buffer occupancy never exceeds its depth.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| flush | input | 1 | Discard this cycle's steering and empty the buffer |
| in_valid | input | NSLOT | Per-entry valid flag, bit i for window entry i |
| in_cnt | input | NSLOT*CNT_W | Micro-op count per entry, entry i at bits [i*CNT_W +: CNT_W] |
| in_tag | input | NSLOT*4 | Tag per entry, entry i at bits [i*4 +: 4] |
| slot_fire | output | NSLOT | Bit i high when entry i is decoded in slot i this cycle |
| consume_cnt | output | 2 | Number of window entries consumed this cycle |
| seq_req | output | 1 | Slot 0 instruction handed to the sequencer this cycle |
| uq_pop | input | 1 | Remove the head micro-op |
| uq_valid | output | 1 | Buffer holds at least one micro-op |
| uq_tag | output | 4 | Tag of the head micro-op |
| uq_idx | output | 2 | Position of the head micro-op within its instruction |
| uq_seq | output | 1 | Head micro-op is a sequencer entry |

## Verification
The bench uses the defaults: three slots, a buffer depth of eight and a three-bit count field. With a depth of eight, two back-to-back four-micro-op instructions fill the buffer exactly. That makes both the equal-space acceptance and the completely-full stall of R5 reachable in a few cycles. The three-bit count reaches the values 5 to 7 that take the sequencer path. Three slots are enough to place a deferred multi-micro-op instruction in either narrow slot, and to show that the run of fired slots always starts at slot 0 and has no gaps.

// File: rtl/dsteer_pkg.sv
package dsteer_pkg;
  // widest micro-op burst the wide slot may emit for one instruction
  localparam int unsigned CPLX_MAX = 4;
  localparam int unsigned TAG_W    = 4;
  localparam int unsigned UIDX_W   = $clog2(CPLX_MAX);

  typedef struct packed {
    logic [TAG_W-1:0]  tag;
    logic [UIDX_W-1:0] idx;
    logic              seq;
  } uop_t;
endpackage

// File: rtl/dsteer_select.sv
module dsteer_select
  import dsteer_pkg::*;
#(
  parameter int unsigned NSLOT  = 3,
  parameter int unsigned CNT_W  = 3,
  parameter int unsigned NUOP_W = 3,
  parameter int unsigned LVL_W  = 4
) (
  input  logic              flush,
  input  logic [NSLOT-1:0]  valid,
  input  logic [CNT_W-1:0]  cnt [NSLOT],
  input  logic [LVL_W-1:0]  free,
  output logic [NSLOT-1:0]  fire,
  output logic              seq0,
  output logic [NUOP_W-1:0] u0,
  output logic [NUOP_W-1:0] nuops
);
  logic [NSLOT-1:0]  take;
  logic [NUOP_W-1:0] total;
  logic              go;

  always_comb begin
    seq0    = cnt[0] > CNT_W'(CPLX_MAX);
    u0      = seq0 ? NUOP_W'(1) : NUOP_W'(cnt[0]);
    take    = '0;
    take[0] = valid[0];
    for (int i = 1; i < NSLOT; i++) begin
      take[i] = take[i-1] & valid[i] & (cnt[i] == CNT_W'(1)) & ~seq0;
    end
    total = take[0] ? u0 : '0;
    for (int i = 1; i < NSLOT; i++) begin
      total = total + NUOP_W'(take[i]);
    end
    go    = ~flush & take[0] & (int'(total) <= int'(free));
    fire  = go ? take  : '0;
    nuops = go ? total : '0;
  end
endmodule

// File: rtl/dsteer_uopq.sv
module dsteer_uopq
  import dsteer_pkg::*;
#(
  parameter int unsigned DEPTH  = 8,
  parameter int unsigned LANES  = 6,
  parameter int unsigned NUOP_W = 3,
  parameter int unsigned LVL_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush,
  input  logic [NUOP_W-1:0] wr_n,
  input  uop_t              wr_data [LANES],
  input  logic              pop,
  output uop_t              head,
  output logic              nonempty,
  output logic [LVL_W-1:0]  level
);
  localparam int unsigned PTR_W = $clog2(DEPTH);

  uop_t             mem [DEPTH];
  logic [PTR_W-1:0] wptr_q, wptr_d, rptr_q, rptr_d;
  logic [LVL_W-1:0] level_q, level_d;
  logic [PTR_W-1:0] widx [LANES];
  logic             pop_ok, en;

  always_comb begin
    pop_ok  = pop & (level_q != '0);
    en      = flush | pop_ok | (wr_n != '0);
    level_d = level_q + LVL_W'(wr_n) - LVL_W'(pop_ok);
    wptr_d  = wptr_q + PTR_W'(wr_n);
    rptr_d  = rptr_q + PTR_W'(pop_ok);
    if (flush) begin
      level_d = '0;
      wptr_d  = '0;
      rptr_d  = '0;
    end
    for (int j = 0; j < LANES; j++) begin
      widx[j] = wptr_q + PTR_W'(j);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      level_q <= '0;
      wptr_q  <= '0;
      rptr_q  <= '0;
    end else if (en) begin
      level_q <= level_d;
      wptr_q  <= wptr_d;
      rptr_q  <= rptr_d;
    end
  end

  always_ff @(posedge clk) begin
    for (int j = 0; j < LANES; j++) begin
      if (!flush && (NUOP_W'(j) < wr_n)) mem[widx[j]] <= wr_data[j];
    end
  end

  assign head     = mem[rptr_q];
  assign nonempty = level_q != '0;
  assign level    = level_q;
endmodule

// File: rtl/dsteer_top.sv
module dsteer_top
  import dsteer_pkg::*;
#(
  parameter int unsigned NSLOT = 3,
  parameter int unsigned DEPTH = 8,
  parameter int unsigned CNT_W = 3
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      flush,
  input  logic [NSLOT-1:0]          in_valid,
  input  logic [NSLOT*CNT_W-1:0]    in_cnt,
  input  logic [NSLOT*TAG_W-1:0]    in_tag,
  output logic [NSLOT-1:0]          slot_fire,
  output logic [$clog2(NSLOT+1)-1:0] consume_cnt,
  output logic                      seq_req,
  input  logic                      uq_pop,
  output logic                      uq_valid,
  output logic [TAG_W-1:0]          uq_tag,
  output logic [UIDX_W-1:0]         uq_idx,
  output logic                      uq_seq
);
  localparam int unsigned LANES  = CPLX_MAX + NSLOT - 1;
  localparam int unsigned NUOP_W = $clog2(LANES + 1);
  localparam int unsigned LVL_W  = $clog2(DEPTH + 1);
  localparam int unsigned CONS_W = $clog2(NSLOT + 1);

  logic [CNT_W-1:0]  cnt_a [NSLOT];
  logic [TAG_W-1:0]  tag_a [NSLOT];
  logic [LVL_W-1:0]  level, free;
  logic [NUOP_W-1:0] u0, nuops;
  logic              seq0;
  uop_t              lane [LANES];
  uop_t              head;

  for (genvar i = 0; i < NSLOT; i++) begin : g_unpack
    assign cnt_a[i] = in_cnt[i*CNT_W +: CNT_W];
    assign tag_a[i] = in_tag[i*TAG_W +: TAG_W];
  end

  assign free = LVL_W'(DEPTH) - level;

  dsteer_select #(
    .NSLOT(NSLOT), .CNT_W(CNT_W), .NUOP_W(NUOP_W), .LVL_W(LVL_W)
  ) sel_i (
    .flush(flush), .valid(in_valid), .cnt(cnt_a), .free(free),
    .fire(slot_fire), .seq0(seq0), .u0(u0), .nuops(nuops)
  );

  // lanes below u0 carry the wide-slot burst; each later lane maps to one narrow slot
  for (genvar j = 0; j < LANES; j++) begin : g_lane
    always_comb begin
      lane[j] = '0;
      if (NUOP_W'(j) < u0) begin
        lane[j] = '{tag: tag_a[0], idx: UIDX_W'(j), seq: seq0};
      end else begin
        for (int s = 1; s < NSLOT; s++) begin
          if (NUOP_W'(j) == u0 + NUOP_W'(s - 1)) begin
            lane[j] = '{tag: tag_a[s], idx: '0, seq: 1'b0};
          end
        end
      end
    end
  end

  dsteer_uopq #(
    .DEPTH(DEPTH), .LANES(LANES), .NUOP_W(NUOP_W), .LVL_W(LVL_W)
  ) q_i (
    .clk(clk), .rst_n(rst_n), .flush(flush), .wr_n(nuops), .wr_data(lane),
    .pop(uq_pop), .head(head), .nonempty(uq_valid), .level(level)
  );

  assign consume_cnt = CONS_W'($countones(slot_fire));
  assign seq_req     = seq0 & slot_fire[0];
  assign uq_tag      = head.tag;
  assign uq_idx      = head.idx;
  assign uq_seq      = head.seq;
endmodule

// File: rtl/dsteer_chk.sv
module dsteer_chk #(
  parameter int unsigned NSLOT  = 3,
  parameter int unsigned DEPTH  = 8,
  parameter int unsigned LVL_W  = 4,
  parameter int unsigned NUOP_W = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              flush,
  input logic [NSLOT-1:0]  fire,
  input logic              seq_req,
  input logic [NUOP_W-1:0] wr_n,
  input logic [LVL_W-1:0]  level,
  input logic              uq_valid
);
  // R9
  level_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    level <= LVL_W'(DEPTH));

  // R3
  fire_prefix_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fire & (fire + NSLOT'(1))) == '0);

  // R4
  seq_alone_chk: assert property (@(posedge clk) disable iff (!rst_n)
    seq_req |-> (fire == NSLOT'(1)));

  // R5
  room_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_n != '0) |-> (int'(wr_n) + int'(level) <= int'(DEPTH)));

  // R7
  flush_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush |-> (fire == '0 && wr_n == '0));

  // R7
  flush_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> !uq_valid);

  // R6
  empty_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!uq_valid && wr_n == '0 && !flush) |=> !uq_valid);
endmodule

bind dsteer_top dsteer_chk #(
  .NSLOT(NSLOT), .DEPTH(DEPTH), .LVL_W(LVL_W), .NUOP_W(NUOP_W)
) chk_i (
  .clk(clk), .rst_n(rst_n), .flush(flush), .fire(slot_fire),
  .seq_req(seq_req), .wr_n(nuops), .level(level), .uq_valid(uq_valid)
);

// File: tb/dsteer_tb.sv
`timescale 1ns/1ps
module dsteer_top_tb_top;
  logic       clk = 1'b0;
  logic       rst_n, flush, uq_pop;
  logic [2:0] in_valid;
  logic [8:0] in_cnt;
  logic [11:0] in_tag;
  logic [2:0] slot_fire;
  logic [1:0] consume_cnt;
  logic       seq_req, uq_valid, uq_seq;
  logic [3:0] uq_tag;
  logic [1:0] uq_idx;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  always #4 clk = ~clk;

  dsteer_top dut_i (
    .clk(clk), .rst_n(rst_n), .flush(flush), .in_valid(in_valid),
    .in_cnt(in_cnt), .in_tag(in_tag), .slot_fire(slot_fire),
    .consume_cnt(consume_cnt), .seq_req(seq_req), .uq_pop(uq_pop),
    .uq_valid(uq_valid), .uq_tag(uq_tag), .uq_idx(uq_idx), .uq_seq(uq_seq)
  );

  // {valid[20:18], c0[17:15], c1[14:12], c2[11:9], cons[8:7], fire[6:4], seq[3], wr[2:0]}
  localparam logic [20:0] VEC [12] = '{
    {3'b111, 3'd1, 3'd1, 3'd1, 2'd3, 3'b111, 1'b0, 3'd3},
    {3'b111, 3'd4, 3'd1, 3'd1, 2'd3, 3'b111, 1'b0, 3'd6},
    {3'b111, 3'd2, 3'd2, 3'd1, 2'd1, 3'b001, 1'b0, 3'd2},
    {3'b111, 3'd1, 3'd3, 3'd1, 2'd1, 3'b001, 1'b0, 3'd1},
    {3'b111, 3'd1, 3'd1, 3'd2, 2'd2, 3'b011, 1'b0, 3'd2},
    {3'b111, 3'd5, 3'd1, 3'd1, 2'd1, 3'b001, 1'b1, 3'd1},
    {3'b000, 3'd1, 3'd1, 3'd1, 2'd0, 3'b000, 1'b0, 3'd0},
    {3'b101, 3'd1, 3'd1, 3'd1, 2'd1, 3'b001, 1'b0, 3'd1},
    {3'b110, 3'd1, 3'd1, 3'd1, 2'd0, 3'b000, 1'b0, 3'd0},
    {3'b111, 3'd7, 3'd1, 3'd1, 2'd1, 3'b001, 1'b1, 3'd1},
    {3'b111, 3'd3, 3'd1, 3'd2, 2'd2, 3'b011, 1'b0, 3'd4},
    {3'b001, 3'd4, 3'd1, 3'd1, 2'd1, 3'b001, 1'b0, 3'd4}
  };

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic drive(input logic [2:0] v, input int c0, input int c1, input int c2,
                       input logic [3:0] t0, input logic [3:0] t1, input logic [3:0] t2);
    in_valid = v;
    in_cnt   = {3'(c2), 3'(c1), 3'(c0)};
    in_tag   = {t2, t1, t0};
  endtask

  // called at a negedge; pops one entry and returns at the next negedge
  task automatic pop_expect(input string req, input int tag, input int idx, input int seq);
    chk({req, " valid"}, int'(uq_valid), 1);
    chk({req, " tag"}, int'(uq_tag), tag);
    chk({req, " idx"}, int'(uq_idx), idx);
    chk({req, " seq"}, int'(uq_seq), seq);
    uq_pop = 1'b1;
    @(negedge clk);
    uq_pop = 1'b0;
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=1 expected=0");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; flush = 1'b0; uq_pop = 1'b0;
    drive(3'b000, 1, 1, 1, 0, 0, 0);
    #3;
    chk("R1 empty in reset", int'(uq_valid), 0);
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    chk("R1 empty after reset", int'(uq_valid), 0);

    // table walk
    for (int v = 0; v < 12; v++) begin
      logic [20:0] e;
      logic [3:0]  tg [3];
      int          n;
      int          c0;
      e = VEC[v];
      for (int i = 0; i < 3; i++) tg[i] = 4'((v * 3 + i) & 15);
      c0 = int'(e[17:15]);
      @(negedge clk);
      drive(e[20:18], c0, int'(e[14:12]), int'(e[11:9]), tg[0], tg[1], tg[2]);
      #2;
      chk($sformatf("R3 fire vec%0d", v), int'(slot_fire), int'(e[6:4]));
      chk($sformatf("R3 consume vec%0d", v), int'(consume_cnt), int'(e[8:7]));
      chk($sformatf("R4 seq vec%0d", v), int'(seq_req), int'(e[3]));
      @(negedge clk);
      in_valid = 3'b000;
      n = 0;
      if (e[8:7] != 0) begin
        if (e[3]) begin
          pop_expect($sformatf("R4 vec%0d", v), int'(tg[0]), 0, 1);
          n++;
        end else begin
          for (int k = 0; k < c0; k++) begin
            pop_expect($sformatf("R2 vec%0d", v), int'(tg[0]), k, 0);
            n++;
          end
        end
        for (int i = 1; i < int'(e[8:7]); i++) begin
          pop_expect($sformatf("R8 vec%0d", v), int'(tg[i]), 0, 0);
          n++;
        end
      end
      chk($sformatf("R6 count vec%0d", v), n, int'(e[2:0]));
      chk($sformatf("R6 drained vec%0d", v), int'(uq_valid), 0);
    end

    // R5: fill to exactly full, then stall, then release by one pop
    @(negedge clk);
    drive(3'b001, 4, 1, 1, 4'hA, 0, 0);
    @(negedge clk);
    drive(3'b001, 4, 1, 1, 4'hB, 0, 0);
    #2;
    chk("R5 equal space accepted", int'(slot_fire), 1);
    @(negedge clk);
    drive(3'b001, 1, 1, 1, 4'hC, 0, 0);
    #2;
    chk("R5 full stall fire", int'(slot_fire), 0);
    chk("R5 full stall consume", int'(consume_cnt), 0);
    @(negedge clk);
    chk("R5 still stalled", int'(consume_cnt), 0);
    pop_expect("R5 head", 10, 0, 0);
    #2;
    chk("R5 released after pop", int'(consume_cnt), 1);
    @(negedge clk);
    in_valid = 3'b000;
    for (int k = 1; k < 4; k++) pop_expect("R5 drain A", 10, k, 0);
    for (int k = 0; k < 4; k++) pop_expect("R5 drain B", 11, k, 0);
    pop_expect("R5 drain C", 12, 0, 0);
    chk("R5 drain exact", int'(uq_valid), 0);

    // R7: flush empties the buffer and suppresses steering
    drive(3'b111, 1, 1, 1, 1, 2, 3);
    @(negedge clk);
    flush = 1'b1;
    #2;
    chk("R7 flush fire", int'(slot_fire), 0);
    chk("R7 flush consume", int'(consume_cnt), 0);
    @(negedge clk);
    flush = 1'b0;
    in_valid = 3'b000;
    chk("R7 empty after flush", int'(uq_valid), 0);

    // R6: pop on empty has no effect on later ordering
    uq_pop = 1'b1;
    @(negedge clk);
    uq_pop = 1'b0;
    drive(3'b011, 1, 1, 1, 5, 6, 0);
    @(negedge clk);
    in_valid = 3'b000;
    pop_expect("R6 after empty pop first", 5, 0, 0);
    pop_expect("R6 after empty pop second", 6, 0, 0);
    chk("R6 empty again", int'(uq_valid), 0);

    // R1: reset with entries present
    drive(3'b001, 3, 1, 1, 7, 0, 0);
    @(negedge clk);
    in_valid = 3'b000;
    chk("R1 filled before reset", int'(uq_valid), 1);
    rst_n = 1'b0;
    #1;
    chk("R1 reset clears", int'(uq_valid), 0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 empty after second reset", int'(uq_valid), 0);

    done = 1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule